// File: doc/BRIEF.md
# Configuration Download and Bus-Access Gate

This block fills the working configuration registers of a supervisory device from its nonvolatile store. A copy runs by itself after reset. After a parameterised settling wait, the block reads the first seven 32-byte pages of the store, one byte per cycle, and writes each byte into the register file at the same low address. The nonvolatile address of a byte is therefore the register address with 0xF8 as the high byte. Software can ask for the same copy again by setting bit 0 of the control register at 0x00D8. That bit clears itself when the copy ends.

Register requests from a serial-bus front end are refused while the block is busy. The block is busy during the settling wait, during any copy and during a page erase. When the block is idle, requests are decoded as follows. Addresses 0xF800 to 0xFBFF reach the nonvolatile store. Page-local address 0x00xx reaches the register file, apart from two control locations. Anything else is refused.

Nonvolatile bytes follow a write-once rule: a byte may be programmed only while it holds the blank value. Writing 5-bit page number p to 0x00D9 erases that whole 32-byte page back to blank.

Top module: `cfgdl_ctrl`

## Requirements
- R1: From reset until the power-up copy ends, `busy` is high and every bus request is answered with `bus_rsp_ok`=0. `busy` stays high for PWRUP_CYCLES + 224 cycles. A request made during a user-requested copy or an erase is refused in the same way.
- R2: The copy writes register addresses 0x00 to 0xDF in ascending order, one per cycle. Each register receives the nonvolatile byte at offset equal to its address, which is bus address 0xF800 + address.
- R3: The copy never writes register addresses 0xE0 to 0xFF. Pages 7 to 31 of the store are never copied.
- R4: A bus write to 0x00D8 with bit 0 set starts the copy of pages 0 to 6 again, which keeps `busy` high for 224 cycles. Afterwards, bit 0 of 0x00D8 reads back 0.
- R5: A bus read of 0xF800 + n returns nonvolatile byte n, for n from 0x000 to 0x3FF.
- R6: A bus write to a nonvolatile byte that holds 0xFF programs the byte and is answered with ok=1. A write to a byte holding any other value leaves the byte unchanged and is answered with ok=0. It also sets a sticky error flag, read at bit 7 of 0x00D8. Writing 0x00D8 with bit 7 set clears the flag.
- R7: A bus write of page number p (bits 4:0) to 0x00D9 sets all 32 bytes at offsets 32p to 32p+31 to 0xFF. `busy` is held high for 32 cycles while this happens.
- R8: Bus reads and writes of 0x0000 to 0x00FF, other than 0x00D8 and 0x00D9, go to the register file at the low byte of the address and are answered with ok=1.
- R9: A request whose high address byte is neither 0x00 nor 0xF8 to 0xFB is answered with ok=0 and writes nothing.
- R10: Every request cycle, whether accepted or refused, is answered by a one-cycle `bus_rsp_valid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with clk |
| bus_req | input | 1 | Request strobe, one cycle per request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rsp_valid | output | 1 | Response strobe, one cycle after the request |
| bus_rsp_ok | output | 1 | 1 = accepted, 0 = refused or rejected |
| bus_rsp_rdata | output | 8 | Read data for accepted reads, 0 otherwise |
| nv_addr | output | 10 | Nonvolatile byte offset |
| nv_we | output | 1 | Nonvolatile write strobe |
| nv_wdata | output | 8 | Nonvolatile write data |
| nv_rdata | input | 8 | Nonvolatile read data, combinational from nv_addr |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | 8 | Register-file address |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data, combinational from rf_addr |
| busy | output | 1 | Copy, erase or power-up wait in progress |

## Verification
The bench times the busy window exactly after reset, after a user trigger and after an erase. An off-by-one in the settling counter or the copy index would change the count, and a copy that stopped early would leave stale registers behind. It compares the whole register image against the store, which catches a copy that skips a byte, shifts addresses or spills into the reserved page. It also writes twice to a blank byte: a design without the blank check would overwrite the byte, and one without a sticky flag would lose the error. Finally, it erases a page that a later user copy must carry into the registers, and checks that the trigger bit reads back cleared.

// File: rtl/cfgdl_pkg.sv
package cfgdl_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_COPY  = 2'd1,
    ST_ERASE = 2'd2,
    ST_IDLE  = 2'd3
  } seq_st_t;

  typedef enum logic [2:0] {
    TGT_RF    = 3'd0,
    TGT_CTRL  = 3'd1,
    TGT_ERASE = 3'd2,
    TGT_NV    = 3'd3,
    TGT_NONE  = 3'd4
  } tgt_t;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;

endpackage

// File: rtl/cfgdl_dec.sv
module cfgdl_dec
  import cfgdl_pkg::*;
#(
  parameter int          NV_AW      = 10,
  parameter logic [15:0] NV_BASE    = 16'hF800,
  parameter logic [7:0]  CTRL_ADDR  = 8'hD8,
  parameter logic [7:0]  ERASE_ADDR = 8'hD9
) (
  input  logic [15:0] addr,
  output tgt_t        tgt
);

  localparam logic [15-NV_AW:0] NV_TAG = NV_BASE[15:NV_AW];

  always_comb begin
    if (addr[15:NV_AW] == NV_TAG) begin
      tgt = TGT_NV;
    end else if (addr[15:8] == 8'h00) begin
      if (addr[7:0] == CTRL_ADDR) begin
        tgt = TGT_CTRL;
      end else if (addr[7:0] == ERASE_ADDR) begin
        tgt = TGT_ERASE;
      end else begin
        tgt = TGT_RF;
      end
    end else begin
      tgt = TGT_NONE;
    end
  end

endmodule

// File: rtl/cfgdl_seq.sv
module cfgdl_seq
  import cfgdl_pkg::*;
#(
  parameter int PWRUP_CYCLES = 50000,
  parameter int PAGE_BYTES   = 32,
  parameter int DL_PAGES     = 7,
  parameter int NV_PAGES     = 32,
  parameter int RF_AW        = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start_dl,
  input  logic                             start_er,
  input  logic [$clog2(NV_PAGES)-1:0]      er_page,
  output logic                             busy,
  output logic                             dl_done,
  output logic                             rf_we,
  output logic [RF_AW-1:0]                 rf_addr,
  output logic                             nv_we,
  output logic [$clog2(NV_PAGES)+$clog2(PAGE_BYTES)-1:0] nv_addr
);

  localparam int DL_BYTES = DL_PAGES * PAGE_BYTES;
  localparam int PAGE_W   = $clog2(PAGE_BYTES);
  localparam int PG_W     = $clog2(NV_PAGES);
  localparam int NV_AW    = PG_W + PAGE_W;
  localparam int IDX_MAX  = (DL_BYTES > PAGE_BYTES) ? DL_BYTES : PAGE_BYTES;
  localparam int IDX_W    = $clog2(IDX_MAX);
  localparam int WAIT_W   = $clog2(PWRUP_CYCLES + 1);

  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(PWRUP_CYCLES - 1);
  localparam logic [IDX_W-1:0]  COPY_LAST = IDX_W'(DL_BYTES - 1);
  localparam logic [IDX_W-1:0]  PAGE_LAST = IDX_W'(PAGE_BYTES - 1);

  seq_st_t             st_q, st_d;
  logic [WAIT_W-1:0]   wcnt_q, wcnt_d;
  logic                wcnt_en;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic                idx_en;
  logic [PG_W-1:0]     page_q, page_d;
  logic                page_en;

  // next-state logic
  always_comb begin
    st_d    = st_q;
    wcnt_d  = wcnt_q + 1'b1;
    wcnt_en = 1'b0;
    idx_d   = idx_q + 1'b1;
    idx_en  = 1'b0;
    page_d  = er_page;
    page_en = 1'b0;
    dl_done = 1'b0;
    rf_we   = 1'b0;
    nv_we   = 1'b0;
    unique case (st_q)
      ST_WAIT: begin
        wcnt_en = 1'b1;
        if (wcnt_q == WAIT_LAST) begin
          st_d   = ST_COPY;
          idx_d  = '0;
          idx_en = 1'b1;
        end
      end
      ST_COPY: begin
        rf_we  = 1'b1;
        idx_en = 1'b1;
        if (idx_q == COPY_LAST) begin
          st_d    = ST_IDLE;
          dl_done = 1'b1;
        end
      end
      ST_ERASE: begin
        nv_we  = 1'b1;
        idx_en = 1'b1;
        if (idx_q == PAGE_LAST) begin
          st_d = ST_IDLE;
        end
      end
      default: begin
        if (start_dl) begin
          st_d   = ST_COPY;
          idx_d  = '0;
          idx_en = 1'b1;
        end else if (start_er) begin
          st_d    = ST_ERASE;
          idx_d   = '0;
          idx_en  = 1'b1;
          page_en = 1'b1;
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_WAIT;
      wcnt_q <= '0;
      idx_q  <= '0;
      page_q <= '0;
    end else begin
      st_q <= st_d;
      if (wcnt_en) wcnt_q <= wcnt_d;
      if (idx_en)  idx_q  <= idx_d;
      if (page_en) page_q <= page_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign rf_addr = RF_AW'(idx_q);
  assign nv_addr = (st_q == ST_ERASE) ? {page_q, idx_q[PAGE_W-1:0]} : NV_AW'(idx_q);

endmodule

// File: rtl/cfgdl_bus.sv
module cfgdl_bus
  import cfgdl_pkg::*;
#(
  parameter int          NV_AW      = 10,
  parameter logic [15:0] NV_BASE    = 16'hF800,
  parameter logic [7:0]  CTRL_ADDR  = 8'hD8,
  parameter logic [7:0]  ERASE_ADDR = 8'hD9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic        wr_go,
  input  logic        wr_clr,
  input  logic        busy,
  input  logic        dl_done,
  input  logic [7:0]  nv_rdata,
  input  logic [7:0]  rf_rdata,
  output logic        start_dl,
  output logic        start_er,
  output logic        bw_nv_we,
  output logic        bw_rf_we,
  output logic        rsp_valid,
  output logic        rsp_ok,
  output logic [7:0]  rsp_rdata
);

  tgt_t       tgt;
  logic       acc;
  logic       ok_d;
  logic [7:0] rd_d;
  logic       err_q, err_d, err_set, err_clr;
  logic       trig_q, trig_d;

  cfgdl_dec #(
    .NV_AW      (NV_AW),
    .NV_BASE    (NV_BASE),
    .CTRL_ADDR  (CTRL_ADDR),
    .ERASE_ADDR (ERASE_ADDR)
  ) u_dec (
    .addr (bus_addr),
    .tgt  (tgt)
  );

  assign acc = bus_req && !busy;

  always_comb begin
    ok_d     = 1'b0;
    rd_d     = 8'h00;
    start_dl = 1'b0;
    start_er = 1'b0;
    bw_nv_we = 1'b0;
    bw_rf_we = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    if (acc) begin
      unique case (tgt)
        TGT_NV: begin
          if (bus_we) begin
            if (nv_rdata == BLANK_BYTE) begin
              bw_nv_we = 1'b1;
              ok_d     = 1'b1;
            end else begin
              err_set = 1'b1;
            end
          end else begin
            ok_d = 1'b1;
            rd_d = nv_rdata;
          end
        end
        TGT_RF: begin
          ok_d = 1'b1;
          if (bus_we) bw_rf_we = 1'b1;
          else        rd_d     = rf_rdata;
        end
        TGT_CTRL: begin
          ok_d = 1'b1;
          if (bus_we) begin
            start_dl = wr_go;
            err_clr  = wr_clr;
          end else begin
            rd_d = {err_q, 6'b000000, trig_q};
          end
        end
        TGT_ERASE: begin
          ok_d     = 1'b1;
          start_er = bus_we;
        end
        default: ok_d = 1'b0;
      endcase
    end
  end

  always_comb begin
    err_d = err_q;
    if (err_set)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    trig_d = trig_q;
    if (start_dl)     trig_d = 1'b1;
    else if (dl_done) trig_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_rdata <= 8'h00;
      err_q     <= 1'b0;
      trig_q    <= 1'b0;
    end else begin
      rsp_valid <= bus_req;
      if (bus_req) begin
        rsp_ok    <= ok_d;
        rsp_rdata <= rd_d;
      end
      err_q  <= err_d;
      trig_q <= trig_d;
    end
  end

endmodule

// File: rtl/cfgdl_ctrl.sv
module cfgdl_ctrl
  import cfgdl_pkg::*;
#(
  parameter int          PWRUP_CYCLES = 50000,
  parameter int          PAGE_BYTES   = 32,
  parameter int          DL_PAGES     = 7,
  parameter int          NV_PAGES     = 32,
  parameter logic [15:0] NV_BASE      = 16'hF800,
  parameter logic [7:0]  CTRL_ADDR    = 8'hD8,
  parameter logic [7:0]  ERASE_ADDR   = 8'hD9,
  localparam int         NV_AW        = $clog2(NV_PAGES) + $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_we,
  input  logic [15:0]      bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic             bus_rsp_valid,
  output logic             bus_rsp_ok,
  output logic [7:0]       bus_rsp_rdata,
  output logic [NV_AW-1:0] nv_addr,
  output logic             nv_we,
  output logic [7:0]       nv_wdata,
  input  logic [7:0]       nv_rdata,
  output logic             rf_we,
  output logic [7:0]       rf_addr,
  output logic [7:0]       rf_wdata,
  input  logic [7:0]       rf_rdata,
  output logic             busy
);

  localparam int PG_W  = $clog2(NV_PAGES);
  localparam int RF_AW = 8;

  logic             seq_busy, seq_done, seq_rf_we, seq_nv_we;
  logic [RF_AW-1:0] seq_rf_addr;
  logic [NV_AW-1:0] seq_nv_addr;
  logic             start_dl, start_er, bw_nv_we, bw_rf_we;
  logic [PG_W-1:0]  er_page;

  assign er_page = bus_wdata[PG_W-1:0];

  cfgdl_seq #(
    .PWRUP_CYCLES (PWRUP_CYCLES),
    .PAGE_BYTES   (PAGE_BYTES),
    .DL_PAGES     (DL_PAGES),
    .NV_PAGES     (NV_PAGES),
    .RF_AW        (RF_AW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_dl (start_dl),
    .start_er (start_er),
    .er_page  (er_page),
    .busy     (seq_busy),
    .dl_done  (seq_done),
    .rf_we    (seq_rf_we),
    .rf_addr  (seq_rf_addr),
    .nv_we    (seq_nv_we),
    .nv_addr  (seq_nv_addr)
  );

  cfgdl_bus #(
    .NV_AW      (NV_AW),
    .NV_BASE    (NV_BASE),
    .CTRL_ADDR  (CTRL_ADDR),
    .ERASE_ADDR (ERASE_ADDR)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .wr_go     (bus_wdata[0]),
    .wr_clr    (bus_wdata[7]),
    .busy      (seq_busy),
    .dl_done   (seq_done),
    .nv_rdata  (nv_rdata),
    .rf_rdata  (rf_rdata),
    .start_dl  (start_dl),
    .start_er  (start_er),
    .bw_nv_we  (bw_nv_we),
    .bw_rf_we  (bw_rf_we),
    .rsp_valid (bus_rsp_valid),
    .rsp_ok    (bus_rsp_ok),
    .rsp_rdata (bus_rsp_rdata)
  );

  // sequencer owns both memory ports while busy, the bus otherwise
  assign nv_addr  = seq_busy ? seq_nv_addr : bus_addr[NV_AW-1:0];
  assign nv_we    = seq_nv_we | bw_nv_we;
  assign nv_wdata = seq_busy ? BLANK_BYTE  : bus_wdata;
  assign rf_addr  = seq_busy ? seq_rf_addr : bus_addr[RF_AW-1:0];
  assign rf_we    = seq_rf_we | bw_rf_we;
  assign rf_wdata = seq_busy ? nv_rdata    : bus_wdata;
  assign busy     = seq_busy;

endmodule

// File: rtl/cfgdl_chk.sv
module cfgdl_chk #(
  parameter int          DL_BYTES = 224,
  parameter int          NV_AW    = 10,
  parameter logic [15:0] NV_BASE  = 16'hF800
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_we,
  input logic [15:0]      bus_addr,
  input logic             bus_rsp_valid,
  input logic             bus_rsp_ok,
  input logic             nv_we,
  input logic [7:0]       nv_wdata,
  input logic [7:0]       nv_rdata,
  input logic             rf_we,
  input logic [7:0]       rf_addr,
  input logic             busy
);

  logic hit_nv, hit_none;
  assign hit_nv   = (bus_addr[15:NV_AW] == NV_BASE[15:NV_AW]);
  assign hit_none = !hit_nv && (bus_addr[15:8] != 8'h00);

  p_refuse_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rsp_valid && $past(busy)) |-> !bus_rsp_ok);

  p_copy_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rf_we) |=> (!(busy && rf_we) || (rf_addr == $past(rf_addr) + 8'd1)));

  p_copy_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rf_we) |-> (int'(rf_addr) < DL_BYTES));

  p_keep_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !busy && hit_nv && nv_rdata != 8'hFF) |-> !nv_we);

  p_reject_used_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !busy && hit_nv && nv_rdata != 8'hFF) |=> !bus_rsp_ok);

  p_erase_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && nv_we) |-> (nv_wdata == 8'hFF));

  p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !busy && hit_none) |-> (!nv_we && !rf_we));

  p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_rsp_valid);

  p_rsp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rsp_valid |-> $past(bus_req));

endmodule

bind cfgdl_ctrl cfgdl_chk #(
  .DL_BYTES (DL_PAGES * PAGE_BYTES),
  .NV_AW    (NV_AW),
  .NV_BASE  (NV_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_req       (bus_req),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_rsp_valid (bus_rsp_valid),
  .bus_rsp_ok    (bus_rsp_ok),
  .nv_we         (nv_we),
  .nv_wdata      (nv_wdata),
  .nv_rdata      (nv_rdata),
  .rf_we         (rf_we),
  .rf_addr       (rf_addr),
  .busy          (busy)
);

// File: tb/test_cfgdl_ctrl.sv
module test_cfgdl_ctrl;

  localparam int PW  = 40;
  localparam int DLB = 224;
  localparam int NVB = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_rsp_valid, bus_rsp_ok;
  logic [7:0]  bus_rsp_rdata;
  logic [9:0]  nv_addr;
  logic        nv_we;
  logic [7:0]  nv_wdata, nv_rdata;
  logic        rf_we;
  logic [7:0]  rf_addr, rf_wdata, rf_rdata;
  logic        busy;

  always #10 clk = ~clk;

  cfgdl_ctrl #(.PWRUP_CYCLES(PW)) i_cfgdl_ctrl (
    .clk (clk), .rst_n (rst_n),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
    .bus_rsp_valid (bus_rsp_valid), .bus_rsp_ok (bus_rsp_ok), .bus_rsp_rdata (bus_rsp_rdata),
    .nv_addr (nv_addr), .nv_we (nv_we), .nv_wdata (nv_wdata), .nv_rdata (nv_rdata),
    .rf_we (rf_we), .rf_addr (rf_addr), .rf_wdata (rf_wdata), .rf_rdata (rf_rdata),
    .busy (busy)
  );

  function automatic logic [7:0] nv_pat(int i);
    if (i >= 'h300) return 8'hFF;
    return 8'((i * 37 + 11) & 'hFF);
  endfunction

  // memory models
  logic [7:0] nvm [NVB];
  logic [7:0] rfm [256];
  logic [7:0] exp_nv [NVB];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVB; i++) nvm[i] <= nv_pat(i);
      for (int i = 0; i < 256; i++) rfm[i] <= 8'h5A;
    end else begin
      if (nv_we) nvm[nv_addr] <= nv_wdata;
      if (rf_we) rfm[rf_addr] <= rf_wdata;
    end
  end
  assign nv_rdata = nvm[nv_addr];
  assign rf_rdata = rfm[rf_addr];

  int n_cmp = 0;
  int n_bad = 0;
  int bcnt  = 0;

  task automatic chk(bit good, string req, int act, int expv);
    n_cmp++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // scoreboard: {check_data, ok, data}
  logic [9:0] sbq [$];
  string      tagq [$];

  always @(negedge clk) begin
    if (rst_n && busy) bcnt++;
    if (rst_n && bus_rsp_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R10 unexpected response", 1, 0);
      end else begin
        logic [9:0] e;
        string      t;
        e = sbq.pop_front();
        t = tagq.pop_front();
        chk(bus_rsp_ok == e[8], {t, " ok"}, bus_rsp_ok, e[8]);
        if (e[9]) chk(bus_rsp_rdata == e[7:0], {t, " data"}, bus_rsp_rdata, e[7:0]);
      end
    end
  end

  task automatic bus_op(bit we, logic [15:0] a, logic [7:0] d, bit eok, bit cdat,
                        logic [7:0] edat, string tag);
    @(negedge clk);
    bus_req   = 1'b1;
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = d;
    sbq.push_back({cdat, eok, edat});
    tagq.push_back(tag);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] e, string tag);
    bus_op(1'b0, a, 8'h00, 1'b1, 1'b1, e, tag);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 20000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  task automatic image_check(string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < DLB; i++)
      if (rfm[i] !== exp_nv[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    chk(bad == 0, {req, " register image matches store"}, bad, 0);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bus_req = 1'b0; bus_we = 1'b0; bus_addr = 16'h0; bus_wdata = 8'h0;
    rst_n = 1'b0;
    for (int i = 0; i < NVB; i++) exp_nv[i] = nv_pat(i);
    repeat (4) @(negedge clk);
    chk(busy == 1'b1, "R1 busy in reset", busy, 1);
    chk(bus_rsp_valid == 1'b0, "R10 no response in reset", bus_rsp_valid, 0);
    bcnt = 0;
    rst_n <= 1'b1;

    // R1: refused during power-up wait, busy window length
    bus_op(1'b0, 16'hF800, 8'h00, 1'b0, 1'b0, 8'h00, "R1 refused while starting");
    wait_idle();
    // release lands at a negedge the counter does not see: PW+224-1 counted
    chk(bcnt == PW + DLB - 1, "R1 power-up busy cycles", bcnt, PW + DLB - 1);

    // R2, R3: register image
    image_check("R2");
    begin
      int bad = 0;
      for (int i = DLB; i < 256; i++) if (rfm[i] !== 8'h5A) bad++;
      chk(bad == 0, "R3 registers 0xE0..0xFF untouched", bad, 0);
    end

    // R5: nonvolatile reads
    rd(16'hF805, nv_pat('h005), "R5 read 0xF805");
    rd(16'hF9FF, nv_pat('h1FF), "R5 read 0xF9FF");
    rd(16'hFB00, 8'hFF, "R5 read blank 0xFB00");

    // R8: register file access
    bus_op(1'b1, 16'h0010, 8'hA5, 1'b1, 1'b0, 8'h00, "R8 write 0x0010");
    rd(16'h0010, 8'hA5, "R8 read 0x0010");

    // R6: write-once rule and sticky flag
    bus_op(1'b1, 16'hFB00, 8'h42, 1'b1, 1'b0, 8'h00, "R6 program blank");
    exp_nv['h300] = 8'h42;
    rd(16'hFB00, 8'h42, "R6 programmed value");
    bus_op(1'b1, 16'hFB00, 8'h13, 1'b0, 1'b0, 8'h00, "R6 reject non-blank");
    rd(16'hFB00, 8'h42, "R6 value kept");
    rd(16'h00D8, 8'h80, "R6 error flag set");
    bus_op(1'b1, 16'h00D8, 8'h00, 1'b1, 1'b0, 8'h00, "R6 write without clear");
    rd(16'h00D8, 8'h80, "R6 error flag sticky");
    bus_op(1'b1, 16'h00D8, 8'h80, 1'b1, 1'b0, 8'h00, "R6 clear flag");
    rd(16'h00D8, 8'h00, "R6 error flag cleared");

    // R9: unmapped addresses
    bus_op(1'b1, 16'h1234, 8'h99, 1'b0, 1'b0, 8'h00, "R9 unmapped write");
    bus_op(1'b0, 16'h1234, 8'h00, 1'b0, 1'b0, 8'h00, "R9 unmapped read");
    rd(16'h0034, nv_pat('h034), "R9 register 0x34 untouched");

    // R7: page erase
    bcnt = 0;
    bus_op(1'b1, 16'h00D9, 8'h03, 1'b1, 1'b0, 8'h00, "R7 erase page 3");
    wait_idle();
    chk(bcnt == 32, "R7 erase busy cycles", bcnt, 32);
    for (int i = 'h60; i < 'h80; i++) exp_nv[i] = 8'hFF;
    rd(16'hF860, 8'hFF, "R7 first byte blank");
    rd(16'hF87F, 8'hFF, "R7 last byte blank");
    rd(16'hF85F, nv_pat('h05F), "R7 previous page kept");
    rd(16'hF880, nv_pat('h080), "R7 next page kept");
    bus_op(1'b1, 16'hF860, 8'h77, 1'b1, 1'b0, 8'h00, "R7 program erased byte");
    exp_nv['h060] = 8'h77;

    // R4: user-requested copy
    bcnt = 0;
    bus_op(1'b1, 16'h00D8, 8'h01, 1'b1, 1'b0, 8'h00, "R4 trigger copy");
    bus_op(1'b0, 16'h0010, 8'h00, 1'b0, 1'b0, 8'h00, "R1 refused during user copy");
    wait_idle();
    chk(bcnt == DLB, "R4 user copy busy cycles", bcnt, DLB);
    image_check("R4");
    rd(16'h00D8, 8'h00, "R4 trigger bit cleared");
    rd(16'h0060, 8'h77, "R4 new byte copied");
    rd(16'h0010, nv_pat('h010), "R4 register restored");

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R10 all responses seen", sbq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule